// File: doc/BRIEF.md
# MDIO Management Master

This block lets software on a register bus run clause-22 management transactions on the serial management bus of an Ethernet PHY. Software writes the target PHY address, the PHY register number and the direction into an address register. For a write it also puts the 16-bit value into a write-data register. It then sets the go bit in the control register, with the enable bit set in the same word. The block derives the management clock from the system clock, shifts out the frame, and clears the go bit when the frame ends. For a read, the value returned by the PHY then sits in the read-data register.

The serial data line is split into an output value, an output enable and an input, so that the pad ring can build the tristate. The management clock idles low and toggles only while a transaction is running. Each half period lasts `DIV` system clocks.

Register select codes on `reg_sel` are 0 for address, 1 for write data, 2 for read data (read-only) and 3 for control. Unused bits read as zero.

Top module: `mdio_mgr`

## Requirements
- R1: The address register (select 0) takes the PHY register number in bits 4:0, the PHY address in bits 9:5 and the direction in bit 10 (1 = read, 0 = write). It reads back bits 10:0 as written, and bits 31:11 read as zero.
- R2: Control (select 3) bit 3 is the enable and reads back as last written. Control bit 0 reads 1 exactly while a transaction is running.
- R3: A control write with bit 0 set starts a transaction only if bit 3 of the same word is set. Otherwise bit 0 stays 0 and the management clock stays low.
- R4: A write frame is 32 ones, then 01, 01, the PHY address MSB first, the register number MSB first, 10, and the 16 data bits MSB first. All 64 bits are driven.
- R5: A read frame carries opcode 10. The output enable is low for the two turnaround bits and the 16 data bits, and high for the first 46 bits.
- R6: During a read, the block samples the input line at each of the 16 data-bit rising edges of the management clock, MSB first. When the transaction ends, the result appears in read-data bits 15:0. A write transaction leaves the read-data register unchanged.
- R7: The management clock is low when idle and has a period of 2·DIV system clocks. A transaction keeps bit 0 set for exactly 128·DIV clock cycles after the edge that accepts the start.
- R8: The fields are captured at start. Register writes and further start requests while a transaction runs do not alter the frame in flight or its length.
- R9: After reset all registers read zero, the management clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_sel | input | 2 | register select |
| reg_wdata | input | 32 | register write value |
| reg_rdata | output | 32 | selected register value |
| mdc | output | 1 | management clock |
| mdio_o | output | 1 | serial data out |
| mdio_oe | output | 1 | serial data output enable |
| mdio_i | input | 1 | serial data in |

## Verification
The assertions assume that the PHY side changes `mdio_i` only well away from the rising edges of the management clock. They also assume that writes arrive as single-cycle strobes with a valid select. The bench PHY model updates the input line one time unit after each rising edge, which leaves a full clock period of setup before the next sample. The bench issues every register write for exactly one cycle, mixing random fields, data and directions from a seeded generator with directed cases for disabled starts and for writes made mid-transaction.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;

    localparam int FRAME_LEN   = 64;
    localparam int TA_POS      = 46;
    localparam int DATA_POS    = 48;
    localparam int IDX_W       = $clog2(FRAME_LEN);
    localparam int CTRL_GO_BIT = 0;
    localparam int CTRL_EN_BIT = 3;
    localparam int CMD_W       = 11;
    localparam int DATA_W      = 16;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    // packed order matches the address register layout: bit10 dir, 9:5 phy, 4:0 reg
    typedef struct packed {
        logic       rd;
        logic [4:0] phy;
        logic [4:0] regn;
    } mdio_cmd_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        op = c.rd ? 2'b10 : 2'b01;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, 2'b10, d};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);

    logic [CW-1:0] cnt_q;
    logic          terminal;

    assign terminal  = (cnt_q == CW'(DIV - 1));
    assign rise_tick = run && terminal && !mdc;
    assign fall_tick = run && terminal && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc); // R7

    AST_MDC_HOLDS_MIDPHASE: assert property (@(posedge clk) disable iff (rst)
        (run && !terminal) |=> $stable(mdc)); // R7

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_shift
);
    logic [FRAME_LEN-1:0] frame_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 rd_mode_q;
    logic                 last_bit;

    assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
    assign rd_done  = busy && fall_tick && last_bit && rd_mode_q;
    assign mdio_o   = busy ? frame_q[FRAME_LEN-1] : 1'b0;
    assign mdio_oe  = busy && (!rd_mode_q || (idx_q < IDX_W'(TA_POS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            frame_q   <= '0;
            idx_q     <= '0;
            rd_mode_q <= 1'b0;
            rd_shift  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                frame_q   <= build_frame(cmd, wdata);
                idx_q     <= '0;
                rd_mode_q <= cmd.rd;
            end
        end else begin
            if (rise_tick && rd_mode_q && (idx_q >= IDX_W'(DATA_POS)))
                rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                if (last_bit) begin
                    busy <= 1'b0;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R9

    AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fall_tick)); // R7

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_mgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_shift,
    output logic [31:0]       rdata,
    output logic              start,
    output mdio_cmd_t         cmd,
    output logic [DATA_W-1:0] wr_val
);
    reg_sel_e          sel_e;
    logic              en_q;
    logic [DATA_W-1:0] rd_q;

    assign sel_e = reg_sel_e'(sel);
    assign start = wr && (sel_e == SEL_CTRL) && wdata[CTRL_GO_BIT]
                   && wdata[CTRL_EN_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd    <= '0;
            wr_val <= '0;
            rd_q   <= '0;
            en_q   <= 1'b0;
        end else begin
            if (wr) begin
                case (sel_e)
                    SEL_ADDR:  cmd    <= mdio_cmd_t'(wdata[CMD_W-1:0]);
                    SEL_WDATA: wr_val <= wdata[DATA_W-1:0];
                    SEL_CTRL:  en_q   <= wdata[CTRL_EN_BIT];
                    default:   ;
                endcase
            end
            if (rd_done)
                rd_q <= rd_shift;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel_e)
            SEL_ADDR:  rdata[CMD_W-1:0]  = cmd;
            SEL_WDATA: rdata[DATA_W-1:0] = wr_val;
            SEL_RDATA: rdata[DATA_W-1:0] = rd_q;
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT] = en_q;
                rdata[CTRL_GO_BIT] = busy;
            end
            default:   ;
        endcase
    end

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (wr && sel_e == SEL_CTRL && !wdata[CTRL_EN_BIT] && !busy) |=> !busy); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(rd_q)); // R6

endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr
    import mdio_mgr_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy, start, rise_tick, fall_tick, rd_done;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] wr_val, rd_shift;

    mdio_regfile u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .busy(busy), .rd_done(rd_done), .rd_shift(rd_shift),
        .rdata(reg_rdata), .start(start), .cmd(cmd), .wr_val(wr_val)
    );

    mdio_clk_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .run(busy),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .wdata(wr_val),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_done(rd_done), .rd_shift(rd_shift)
    );

endmodule

// File: tb/test_mdio_mgr.sv
module test_mdio_mgr;
    localparam int DIV = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0, mdio_i = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mdc, mdio_o, mdio_oe;

    int          n_chk = 0, n_bad = 0;
    int          rises = 0;
    logic [63:0] cap = '0, oecap = '0;
    logic [15:0] phy_data = '0;

    always #2.5 clk = ~clk;

    mdio_mgr #(.DIV(DIV)) i_mdio_mgr (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic [63:0] exp_frame(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    endfunction

    function automatic logic phy_bit(int n, logic [15:0] d);
        if (n >= 48 && n <= 63) return d[63 - n];
        return 1'b1;
    endfunction

    // PHY model: records the line at each rising edge, presents the next bit afterwards
    initial forever begin
        @(posedge mdc);
        cap   = {cap[62:0], mdio_o};
        oecap = {oecap[62:0], mdio_oe};
        rises = rises + 1;
        #1 mdio_i = phy_bit(rises, phy_data);
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic reg_write(logic [1:0] s, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic run_txn(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d, bit disturb);
        int          n;
        logic [63:0] e;
        logic [31:0] v;
        logic [15:0] prev_rd;
        reg_read(2'd2, v);
        prev_rd = v[15:0];
        reg_write(2'd0, {21'd0, rd, phy, rg});
        reg_write(2'd1, {16'd0, d});
        phy_data = $urandom;
        rises = 0; cap = '0; oecap = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h9;
        n = 0;
        forever begin
            @(negedge clk);
            reg_wr = 1'b0; reg_sel = 2'd3;
            #1;
            if (!reg_rdata[0] || n > 200 * DIV) break;
            n++;
            if (disturb && n == 50) begin
                reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = {21'd0, ~rd, ~phy, ~rg};
            end else if (disturb && n == 51) begin
                reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h9;
            end else if (disturb && n == 52) begin
                reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = {16'd0, ~d};
            end
        end
        check(n == 128 * DIV, disturb ? "R8 length" : "R7 busy length", 64'(n), 64'(128 * DIV));
        check(rises == 64, "R7 clock edges", 64'(rises), 64'd64);
        check(mdc == 1'b0, "R7 idle low", {63'd0, mdc}, 64'd0);
        e = exp_frame(rd, phy, rg, d);
        if (rd) begin
            check((cap >> 18) == (e >> 18), disturb ? "R8 frame" : "R5 read frame", cap >> 18, e >> 18);
            check(oecap == {{46{1'b1}}, 18'd0}, "R5 oe", oecap, {{46{1'b1}}, 18'd0});
            reg_read(2'd2, v);
            check(v == {16'd0, phy_data}, "R6 read data", 64'(v), 64'(phy_data));
        end else begin
            check(cap == e, disturb ? "R8 frame" : "R4 write frame", cap, e);
            check(oecap == '1, "R4 oe", oecap, '1);
            reg_read(2'd2, v);
            check(v[15:0] == prev_rd, "R6 write keeps rdata", 64'(v), 64'(prev_rd));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        reg_read(2'd0, v); check(v == 0, "R9 addr", 64'(v), 0);
        reg_read(2'd2, v); check(v == 0, "R9 rdata", 64'(v), 0);
        reg_read(2'd3, v); check(v == 0, "R9 ctrl", 64'(v), 0);
        check(mdc == 0 && mdio_oe == 0, "R9 pins", {62'd0, mdc, mdio_oe}, 0);
        // R3 start without enable
        rises = 0;
        reg_write(2'd3, 32'h1);
        repeat (3 * DIV) @(negedge clk);
        reg_read(2'd3, v); check(v == 0, "R3 no start", 64'(v), 0);
        check(rises == 0, "R3 mdc quiet", 64'(rises), 0);
        // R2 enable readback
        reg_write(2'd3, 32'h8);
        reg_read(2'd3, v); check(v == 32'h8, "R2 enable", 64'(v), 64'h8);
        // R1 address readback
        reg_write(2'd0, 32'hFFFF_F5A3);
        reg_read(2'd0, v); check(v == 32'h5A3, "R1 addr fields", 64'(v), 64'h5A3);
        // directed corners
        run_txn(1'b0, 5'd31, 5'd0, 16'hFFFF, 1'b0);
        run_txn(1'b1, 5'd0, 5'd31, 16'h0, 1'b0);
        run_txn(1'b0, 5'd1, 5'd1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'd10, 5'd21, 16'hA5C3, 1'b1);
        run_txn(1'b1, 5'd3, 5'd4, 16'h0, 1'b1);
        // random mix
        for (int k = 0; k < 8; k++)
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 1'b0);
        finish_run();
    end
endmodule